// File: doc/BRIEF.md
# Accumulator Readout and Transfer Sequencer

This block runs block transfers between an accumulation memory (words of `DW` bits) and a lookup memory (words of `OW` bits), both `2**AW` entries deep and both outside the block. One falling edge on the active-low start input begins a transfer. The transfer walks addresses upward from 0, one per clock. It can do one of four things: read accumulator words out to the output bus, copy processed accumulator words into the lookup memory, read lookup words out, or load the lookup memory from the coefficient bus. The user ends a transfer early by raising start again. If start stays low, the transfer covers the whole memory and ends by itself.

Each accumulator word can first be replaced by the running total of the words read so far in the transfer. A 9-bit window is then cut from it at a chosen offset, with an optional saturation. The block can also clear accumulator locations as it goes: on every access, on accumulator accesses only, or never. The output-valid flag follows the address stream after a fixed three-clock delay. A busy flag covers the whole transfer, so the caller can hold off pixel-rate work while it is high.

Both memories are modelled as synchronous: a word is returned one clock after its address is presented with a read strobe. When the accumulator clear strobe is high, that location is written with zero at the same edge, and a read in that cycle still returns the old word.

Top module: `acc_xfer_seq`

## Requirements
- R1: A transfer begins only when a clock edge samples `start_n` low after the previous edge sampled it high, and only while `busy` is low. A falling edge that arrives while `busy` is high is ignored. `busy` rises at the starting edge and falls in the same cycle as `dout_valid`.
- R2: Addresses are issued in order from 0, one per clock. The first word and `dout_valid` appear three clocks after the starting edge.
- R3: If the k-th edge after the starting edge samples `start_n` high, exactly k words are transferred, and `dout_valid` falls three clocks after that edge.
- R4: If `start_n` stays low, exactly `2**AW` words are transferred and `dout_valid` then falls on its own. After that, the level of `start_n` starts nothing until a new falling edge arrives.
- R5: `op[0]`,`op[1]` select the operation: 0,0 copies processed accumulator words into the lookup memory at the same address; 0,1 reads accumulator words to `dout`; 1,0 reads lookup words to `dout` unchanged; 1,1 writes lookup memory.
- R6: `dout` for an accumulator word is bits `sel` through `sel+8` of the processed word, with `sel` from 0 to 15.
- R7: When `sat` is 1 and any bit of the processed word above the window is 1, `dout` is 511.
- R8: When `eq` is 1, the processed word is the 24-bit running sum (modulo 2**24) of all accumulator words read so far in the transfer, including the current one. Windowing and saturation are applied after the sum.
- R9: `clr_mode[0]`,`clr_mode[1]`: 0,0 clears each accumulator location whose address is issued in any operation. 1,0 clears only in the two accumulator operations. 1,1 and 0,1 never clear.
- R10: In the lookup-write operation, the `ci` value present in the cycle an address is issued is stored at that address, and `dout` reads 0 while valid.
- R11: `op`, `clr_mode`, `sel`, `sat` and `eq` are sampled at the starting edge. Changing them during a transfer does not affect it.
- R12: While in reset and after it, with no transfer running, `busy`, `dout_valid`, `dout` and all memory strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start request, active low, acts on its falling edge |
| op | input | 2 | Operation select |
| clr_mode | input | 2 | Accumulator clearing policy |
| sel | input | 4 | Window offset |
| sat | input | 1 | Saturate on bits above the window |
| eq | input | 1 | Running-sum enable |
| ci | input | OW | Coefficient data for lookup writes |
| acc_addr | output | AW | Accumulator address |
| acc_rd | output | 1 | Accumulator read strobe |
| acc_clr | output | 1 | Accumulator clear strobe |
| acc_rdata | input | DW | Accumulator read data, one clock after the strobe |
| lut_addr | output | AW | Lookup address |
| lut_rd | output | 1 | Lookup read strobe |
| lut_we | output | 1 | Lookup write strobe |
| lut_wdata | output | OW | Lookup write data |
| lut_rdata | input | OW | Lookup read data, one clock after the strobe |
| dout | output | OW | Output word |
| dout_valid | output | 1 | `dout` holds a transferred word |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest cases to reach are a fresh falling edge on start while the pipeline is still draining after an early stop, and a full-length transfer with start still held low after it ends. The stimulus makes both directly: it pulls start low again in the cycle after raising it, and it keeps start low for several cycles after a 512-word transfer. In both cases it expects `busy` to stay low. Configuration inputs are changed partway through one transfer, including a switch to a clearing policy. The checks then compare the memory contents against shadows that follow only the policy sampled at the start.

// File: rtl/acc_xfer_seq.sv
module acc_xfer_seq #(
  parameter int AW = 9,
  parameter int DW = 24,
  parameter int OW = 9,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic [1:0]    op,
  input  logic [1:0]    clr_mode,
  input  logic [SW-1:0] sel,
  input  logic          sat,
  input  logic          eq,
  input  logic [OW-1:0] ci,
  output logic [AW-1:0] acc_addr,
  output logic          acc_rd,
  output logic          acc_clr,
  input  logic [DW-1:0] acc_rdata,
  output logic [AW-1:0] lut_addr,
  output logic          lut_rd,
  output logic          lut_we,
  output logic [OW-1:0] lut_wdata,
  input  logic [OW-1:0] lut_rdata,
  output logic [OW-1:0] dout,
  output logic          dout_valid,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          start_q, run, v1, v2, v3;
  logic [AW-1:0] addr, a1, a2, a3;
  logic [1:0]    op_q, cm_q;
  logic [SW-1:0] sel_q;
  logic          sat_q, eq_q;
  logic [DW-1:0] word2;
  logic [OW-1:0] dout_q;

  assign busy = run | v1 | v2 | v3;
  wire go       = start_q & ~start_n & ~busy;
  wire acc_mode = ~op_q[0];
  wire copy     = (op_q == 2'b00);
  wire wr_lut   = (op_q == 2'b11);

  wire [DW-1:0] shifted = word2 >> sel_q;
  wire          over    = |shifted[DW-1:OW];
  wire [OW-1:0] shaped  = (sat_q & over) ? {OW{1'b1}} : shifted[OW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      run     <= 1'b0;
      addr    <= '0;
      op_q    <= '0;
      cm_q    <= 2'b11;
      sel_q   <= '0;
      sat_q   <= 1'b0;
      eq_q    <= 1'b0;
    end else begin
      start_q <= start_n;
      if (go) begin
        run   <= 1'b1;
        addr  <= '0;
        op_q  <= op;
        cm_q  <= clr_mode;
        sel_q <= sel;
        sat_q <= sat;
        eq_q  <= eq;
      end else if (run) begin
        if (start_n || addr == LAST) run <= 1'b0;
        addr <= addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3} <= '0;
      {a1, a2, a3} <= '0;
      word2        <= '0;
      dout_q       <= '0;
    end else begin
      v1 <= run;
      v2 <= v1;
      v3 <= v2;
      a1 <= addr;
      a2 <= a1;
      a3 <= a2;
      if (go)
        word2 <= '0;
      else if (v1)
        word2 <= acc_mode ? ((eq_q ? word2 : '0) + acc_rdata)
                          : {{(DW-OW){1'b0}}, lut_rdata};
      if (v2)
        dout_q <= wr_lut ? '0 : (acc_mode ? shaped : word2[OW-1:0]);
      else
        dout_q <= '0;
    end
  end

  assign acc_addr   = addr;
  assign acc_rd     = run & acc_mode;
  assign acc_clr    = run & ((cm_q == 2'b00) | ((cm_q == 2'b01) & acc_mode));
  assign lut_addr   = copy ? a3 : addr;
  assign lut_rd     = run & (op_q == 2'b01);
  assign lut_we     = (run & wr_lut) | (v3 & copy);
  assign lut_wdata  = copy ? dout_q : ci;
  assign dout       = dout_q;
  assign dout_valid = v3;
endmodule

// File: rtl/acc_xfer_seq_chk.sv
module acc_xfer_seq_chk #(
  parameter int AW = 9
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic dout_valid,
  input logic acc_rd,
  input logic acc_clr,
  input logic lut_rd,
  input logic lut_we
);
  logic [AW:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (dout_valid) vcnt <= vcnt + 1'b1;
    else vcnt <= '0;
  end

  p_first_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ##3 $rose(dout_valid));

  p_valid_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> busy);

  p_drop_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_valid) |-> !busy);

  p_max_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> !vcnt[AW]);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(acc_rd || acc_clr || lut_rd || lut_we));

  p_clear_in_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |-> busy && !dout_valid || busy);
endmodule

bind acc_xfer_seq acc_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dout_valid(dout_valid),
  .acc_rd(acc_rd), .acc_clr(acc_clr), .lut_rd(lut_rd), .lut_we(lut_we)
);

// File: tb/tb_acc_xfer_seq.sv
module tb_acc_xfer_seq;
  localparam int CLK_P = 10;
  localparam int N = 512;

  logic clk = 0, rst_n = 0, start_n = 1;
  logic [1:0] op_i = 0, cm_i = 2'b11;
  logic [3:0] sel_i = 0;
  logic sat_i = 0, eq_i = 0;
  logic [8:0] ci = 0;
  logic [8:0] acc_addr, lut_addr, lut_wdata, dout;
  logic acc_rd, acc_clr, lut_rd, lut_we, dout_valid, busy;
  logic [23:0] acc_rdata = 0;
  logic [8:0] lut_rdata = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .op(op_i), .clr_mode(cm_i),
    .sel(sel_i), .sat(sat_i), .eq(eq_i), .ci(ci),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_clr(acc_clr), .acc_rdata(acc_rdata),
    .lut_addr(lut_addr), .lut_rd(lut_rd), .lut_we(lut_we), .lut_wdata(lut_wdata),
    .lut_rdata(lut_rdata), .dout(dout), .dout_valid(dout_valid), .busy(busy)
  );

  logic [23:0] accm [N];
  logic [8:0]  lutm [N];
  logic [23:0] sh_acc [N];
  logic [8:0]  sh_lut [N];
  logic [8:0]  expq [$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int vcount, first_v, last_v;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (acc_rd) acc_rdata <= accm[acc_addr];
    if (acc_clr) accm[acc_addr] <= '0;
    if (lut_rd) lut_rdata <= lutm[lut_addr];
    if (lut_we) lutm[lut_addr] <= lut_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dout_valid) begin
    vcount++;
    if (first_v < 0) first_v = cyc;
    last_v = cyc;
    if (expq.size() == 0) check(0, "R2 extra word", dout, -1);
    else begin
      logic [8:0] e;
      e = expq.pop_front();
      check(dout == e, "R5/R6/R7/R8/R10 data", dout, e);
    end
  end

  function automatic logic [8:0] win(input logic [23:0] w, input logic [3:0] s, input bit st);
    logic [23:0] hi;
    hi = w >> s;
    return (st && (hi >> 9) != 0) ? 9'h1FF : hi[8:0];
  endfunction

  function automatic logic [8:0] cpat(input int i);
    return 9'((i * 37 + 5) & 511);
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < N; i++) begin
      accm[i] = (i % 4 == 0) ? 24'(i + seed) : 24'((i * 24'h01F3A7 + i * i * 13 + seed) & 24'hFFFFFF);
      sh_acc[i] = accm[i];
    end
  endtask

  task automatic cmp_mem(input string req);
    int ba = -1, bl = -1;
    for (int i = 0; i < N; i++) begin
      if (ba < 0 && accm[i] !== sh_acc[i]) ba = i;
      if (bl < 0 && lutm[i] !== sh_lut[i]) bl = i;
    end
    check(ba < 0, {req, " accumulator contents"}, ba < 0 ? 0 : accm[ba], ba < 0 ? 0 : sh_acc[ba]);
    check(bl < 0, {req, " lookup contents"}, bl < 0 ? 0 : lutm[bl], bl < 0 ? 0 : sh_lut[bl]);
  endtask

  task automatic xfer(input logic [1:0] op, input logic [1:0] cm, input logic [3:0] s,
                      input bit st, input bit e, input int k, input bit chg, input bit refall);
    logic [23:0] sum = 0;
    bit longc = (k == N);
    int t0, guard;
    for (int i = 0; i < k; i++) begin
      logic [23:0] w;
      logic [8:0] o;
      if (op[0] == 1'b0) begin
        sum = sum + sh_acc[i];
        w = e ? sum : sh_acc[i];
        o = win(w, s, st);
        if (op[1] == 1'b0) sh_lut[i] = o;
      end else if (op[1] == 1'b0) o = sh_lut[i];
      else begin
        o = 0;
        sh_lut[i] = cpat(i);
      end
      expq.push_back(o);
      if (cm == 2'b00 || (cm == 2'b01 && op[0] == 1'b0)) sh_acc[i] = 0;
    end
    @(negedge clk); @(negedge clk);
    op_i = op; cm_i = cm; sel_i = s; sat_i = st; eq_i = e;
    vcount = 0; first_v = -1; last_v = -1;
    start_n = 0; t0 = cyc;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (i == 0) check(busy == 1, "R1 busy at start", busy, 1);
      ci = cpat(i);
      if (chg && i == 1) begin
        sel_i = ~s; eq_i = ~e; sat_i = ~st; cm_i = 2'b00;
      end
      if (i == k - 1 && !longc) start_n = 1;
    end
    if (refall) begin
      @(negedge clk);
      start_n = 0;
    end
    guard = 0;
    while (busy && guard < 20) begin @(negedge clk); guard++; end
    check(dout_valid == 0 && busy == 0, "R1 busy falls with valid", busy, 0);
    check(vcount == k, longc ? "R4 word count" : "R3 word count", vcount, k);
    check(first_v - t0 == 4, "R2 first valid latency", first_v - t0, 4);
    check(last_v - t0 == k + 3, longc ? "R4 end" : "R3 valid drop", last_v - t0, k + 3);
    check(expq.size() == 0, "R2 words missing", expq.size(), 0);
    expq.delete();
    if (longc || refall) begin
      repeat (6) begin
        @(negedge clk);
        check(busy == 0 && dout_valid == 0, refall ? "R1 fall while busy ignored" : "R4 start level ignored", busy, 0);
      end
    end
    start_n = 1;
    cmp_mem(chg ? "R11" : (op == 2'b11 ? "R10" : "R9"));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill(3);
    for (int i = 0; i < N; i++) begin lutm[i] = 9'(i ^ 9'h0A5); sh_lut[i] = lutm[i]; end
    repeat (3) @(negedge clk);
    check(busy == 0 && dout_valid == 0 && dout == 0, "R12 reset state", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!acc_rd && !acc_clr && !lut_rd && !lut_we && !busy, "R12 idle after reset", busy, 0);

    xfer(2'b10, 2'b11, 4'd0,  0, 0, 5,   0, 0);  // R5 R6 R3
    xfer(2'b10, 2'b11, 4'd3,  1, 0, N,   0, 0);  // R4 R7
    xfer(2'b10, 2'b11, 4'd8,  1, 1, 20,  1, 0);  // R8 R11
    xfer(2'b00, 2'b01, 4'd12, 0, 1, N,   0, 0);  // R5 copy, R9 acc-only clear
    fill(77);
    xfer(2'b01, 2'b00, 4'd0,  0, 0, 7,   0, 0);  // R9 clear on lookup access
    xfer(2'b11, 2'b11, 4'd0,  0, 0, 9,   0, 0);  // R10 short write
    xfer(2'b11, 2'b00, 4'd0,  0, 0, N,   0, 0);  // R10 long write, R9
    fill(1234);
    xfer(2'b10, 2'b01, 4'd5,  0, 0, 30,  0, 0);  // R9 clear on accumulator read
    xfer(2'b01, 2'b01, 4'd0,  0, 0, 6,   0, 1);  // R9 no clear, R1 ignored fall
    xfer(2'b10, 2'b11, 4'd15, 1, 1, 1,   0, 0);  // R6 top window, R3 single word

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule